// File: doc/BRIEF.md
# Cascaded Non-Preemptive DMA Bus Arbiter

This block decides which of eight DMA request lines gets the system bus. The channels form two groups of four, and the lowest channel of the upper group acts only as the link between the groups. Before it can hand the bus to a channel, the arbiter asks the CPU for the bus with a hold request and waits for the hold acknowledge to come back. It then asserts one acknowledge line for the winning channel.

Priority is only used while the bus is free. Once a channel owns the bus it keeps it until its own transfer mode releases it. A single-mode channel owns the bus for one cycle, which stands for one byte. A demand-mode channel owns it for as long as its request stays high. A bus-master channel also keeps its acknowledge while its request is high, and during that time the arbiter drives no transfer cycles. After every release the arbiter rescans all request lines. It gives the bus back to the CPU only when no request is pending. The transfer mode and the bus-master option are static, per-channel configuration inputs.

Top module: `cascade_dma_arbiter`

## Requirements
- R1: After reset, `busHold`, `chanAck`, `busy` and `cycleDrive` are all low.
- R2: `busHold` rises one clock after a valid request is seen while the bus is idle. No `chanAck` bit is set until `holdAck` has been sampled high.
- R3: When several requests are pending, the arbiter grants the lowest-numbered valid channel. The order is 0, 1, 2, 3, 5, 6, 7.
- R4: Channel 4 is the group link. Its request never raises `busHold` and never gets an acknowledge, and `chanAck[4]` is always 0.
- R5: While a channel owns the bus, no newly raised request moves the acknowledge to another channel. This holds even when the new request has higher priority.
- R6: A demand-mode channel (`demandMode` bit = 1) keeps its acknowledge while its request is high. The acknowledge clears one clock after the request is sampled low.
- R7: A single-mode channel (`demandMode` bit = 0, `masterMode` bit = 0) holds its acknowledge for exactly one clock. It must then win arbitration again for the next byte.
- R8: After a grant ends, the next clock grants the highest-priority request still pending, and `busHold` stays high in between.
- R9: After a grant ends with no request pending, `busHold` drops on the next clock.
- R10: A request that drops before it is granted is forgotten. The bus returns to idle with no acknowledge.
- R11: A bus-master channel (`masterMode` bit = 1) keeps its acknowledge while its request is high, with `cycleDrive` low. Any other grant has `cycleDrive` high.
- R12: `chanAck` is one-hot or zero, and `busy` is high exactly when some acknowledge bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chanReq | input | 8 | Per-channel DMA request, sampled synchronously |
| demandMode | input | 8 | Per-channel mode: 1 = demand, 0 = single byte |
| masterMode | input | 8 | Per-channel bus-master option |
| holdAck | input | 1 | CPU has given up the bus |
| busHold | output | 1 | Request for the bus to the CPU |
| chanAck | output | 8 | One-hot channel acknowledge |
| busy | output | 1 | A channel owns the bus |
| cycleDrive | output | 1 | Arbiter drives transfer cycles for the current owner |

## Verification
The bench raises a higher-priority request while a lower one owns the bus. A preempting design would move the acknowledge. It drives a request on the link channel alone, which a design that fails to mask it would grant. It also drops a request between `busHold` and `holdAck`, which a design that latched too early would still grant. Single-mode runs check the one-cycle acknowledge with a gap between bytes, and rescans check that the highest pending channel wins and that the bus is returned on the cycle after the last release. A master-mode grant checks that `cycleDrive` stays low for the whole ownership.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_OWN  = 2'd2
  } arbState_t;

  typedef struct packed {
    logic grantLoad;
    logic grantClear;
  } arbStrobe_t;

endpackage

// File: rtl/dma_arb_path.sv
module dma_arb_path
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int GROUP_SIZE = 4,
  parameter int LINK_CH    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chanReq,
  input  logic [NUM_CH-1:0] demandMode,
  input  logic [NUM_CH-1:0] masterMode,
  input  arbStrobe_t        strobe,
  output logic              anyPend,
  output logic              ownerReq,
  output logic              ownerHold,
  output logic [NUM_CH-1:0] chanAck,
  output logic              cycleDrive
);

  localparam int NUM_GRP = NUM_CH / GROUP_SIZE;
  localparam logic [NUM_CH-1:0] LINK_MASK = {{(NUM_CH-1){1'b0}}, 1'b1} << LINK_CH;

  logic [NUM_CH-1:0]     validReq;
  logic [NUM_CH-1:0]     grpPick;
  logic [NUM_GRP-1:0]    grpAny;
  logic [NUM_GRP-1:0]    grpWin;
  logic [NUM_CH-1:0]     winner;
  logic [NUM_CH-1:0]     ackReg;

  assign validReq = chanReq & ~LINK_MASK;

  // Per-group fixed priority: lowest index inside the group wins.
  for (genvar g = 0; g < NUM_GRP; g++) begin : gGroup
    logic [GROUP_SIZE-1:0] grpReq;
    assign grpReq = validReq[g*GROUP_SIZE +: GROUP_SIZE];
    assign grpPick[g*GROUP_SIZE +: GROUP_SIZE] = grpReq & (~grpReq + 1'b1);
    assign grpAny[g] = |grpReq;
  end

  // Cascade stage: lower group outranks upper group.
  assign grpWin = grpAny & (~grpAny + 1'b1);

  always_comb begin
    winner = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grpWin[g]) winner[g*GROUP_SIZE +: GROUP_SIZE] = grpPick[g*GROUP_SIZE +: GROUP_SIZE];
    end
  end

  assign anyPend = |grpAny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackReg <= '0;
    end else if (strobe.grantLoad) begin
      ackReg <= winner;
    end else if (strobe.grantClear) begin
      ackReg <= '0;
    end
  end

  assign chanAck    = ackReg;
  assign ownerReq   = |(ackReg & chanReq);
  assign ownerHold  = |(ackReg & (demandMode | masterMode));
  assign cycleDrive = |(ackReg & ~masterMode);

endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       anyPend,
  input  logic       ownerReq,
  input  logic       ownerHold,
  input  logic       holdAck,
  output arbStrobe_t strobe,
  output logic       busHold,
  output logic       busy
);

  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (anyPend) stateNext = ST_ARB;
      end
      ST_ARB: begin
        if (!anyPend) begin
          stateNext = ST_IDLE;
        end else if (holdAck) begin
          stateNext        = ST_OWN;
          strobe.grantLoad = 1'b1;
        end
      end
      ST_OWN: begin
        // single-byte owners always release; others release when request drops
        if (!ownerHold || !ownerReq) begin
          stateNext         = ST_ARB;
          strobe.grantClear = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busHold = (state != ST_IDLE);
  assign busy    = (state == ST_OWN);

endmodule

// File: rtl/cascade_dma_arbiter.sv
module cascade_dma_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int GROUP_SIZE = 4,
  parameter int LINK_CH    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chanReq,
  input  logic [NUM_CH-1:0] demandMode,
  input  logic [NUM_CH-1:0] masterMode,
  input  logic              holdAck,
  output logic              busHold,
  output logic [NUM_CH-1:0] chanAck,
  output logic              busy,
  output logic              cycleDrive
);

  arbStrobe_t strobe;
  logic anyPend, ownerReq, ownerHold;

  dma_arb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .anyPend  (anyPend),
    .ownerReq (ownerReq),
    .ownerHold(ownerHold),
    .holdAck  (holdAck),
    .strobe   (strobe),
    .busHold  (busHold),
    .busy     (busy)
  );

  dma_arb_path #(
    .NUM_CH    (NUM_CH),
    .GROUP_SIZE(GROUP_SIZE),
    .LINK_CH   (LINK_CH)
  ) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .chanReq   (chanReq),
    .demandMode(demandMode),
    .masterMode(masterMode),
    .strobe    (strobe),
    .anyPend   (anyPend),
    .ownerReq  (ownerReq),
    .ownerHold (ownerHold),
    .chanAck   (chanAck),
    .cycleDrive(cycleDrive)
  );

endmodule

// File: rtl/cascade_dma_arbiter_chk.sv
module cascade_dma_arbiter_chk #(
  parameter int NUM_CH  = 8,
  parameter int LINK_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chanReq,
  input logic [NUM_CH-1:0] demandMode,
  input logic [NUM_CH-1:0] masterMode,
  input logic              holdAck,
  input logic              busHold,
  input logic [NUM_CH-1:0] chanAck,
  input logic              busy
);

  // R12
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chanAck) && (busy == (|chanAck)));

  // R2
  ack_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chanAck) && !$past(|chanAck)) |-> ($past(holdAck) && busHold));

  // R4
  link_never_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chanAck[LINK_CH] == 1'b0);

  // R5
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chanAck) && $past(|chanAck)) |-> (chanAck == $past(chanAck)));

  // R6
  demand_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chanAck & chanReq & (demandMode | masterMode))) |=> $stable(chanAck));

  // R7
  single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chanAck & ~demandMode & ~masterMode)) |=> (chanAck == '0));

endmodule

bind cascade_dma_arbiter cascade_dma_arbiter_chk #(.NUM_CH(NUM_CH), .LINK_CH(LINK_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chanReq   (chanReq),
  .demandMode(demandMode),
  .masterMode(masterMode),
  .holdAck   (holdAck),
  .busHold   (busHold),
  .chanAck   (chanAck),
  .busy      (busy)
);

// File: tb/cascade_dma_arbiter_tb.sv
module cascade_dma_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] chanReq = '0;
  logic [7:0] demandMode = 8'b1111_1011;  // ch2 single byte
  logic [7:0] masterMode = 8'b0100_0000;  // ch6 bus master
  logic       holdAck = 1'b0;
  logic       busHold, busy, cycleDrive;
  logic [7:0] chanAck;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] ack;
    logic       hold;
    logic       bsy;
    logic       drv;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;

  cascade_dma_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .chanReq(chanReq), .demandMode(demandMode),
    .masterMode(masterMode), .holdAck(holdAck), .busHold(busHold),
    .chanAck(chanAck), .busy(busy), .cycleDrive(cycleDrive)
  );

  // Driver: apply inputs on the falling edge, queue the outputs expected after the next rise.
  task automatic cyc(input logic [7:0] r, input logic ha, input logic [7:0] ea,
                     input logic eh, input string tag);
    exp_t x;
    @(negedge clk);
    chanReq = r;
    holdAck = ha;
    x.ack  = ea;
    x.hold = eh;
    x.bsy  = |ea;
    x.drv  = |(ea & ~masterMode);
    x.tag  = tag;
    q.push_back(x);
  endtask

  // Monitor: compare 5 ns after each rising edge.
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      nChecks++;
      if (chanAck !== e.ack || busHold !== e.hold || busy !== e.bsy || cycleDrive !== e.drv) begin
        nErrors++;
        $display("FAIL %s: ack=%b hold=%b busy=%b drv=%b expected ack=%b hold=%b busy=%b drv=%b",
                 e.tag, chanAck, busHold, busy, cycleDrive, e.ack, e.hold, e.bsy, e.drv);
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    begin
      exp_t x;
      @(negedge clk);
      rst_n = 1'b1;
      x.ack = 8'h00; x.hold = 0; x.bsy = 0; x.drv = 0; x.tag = "R1 reset state";
      q.push_back(x);
    end

    // Priority, hold handshake, non-preemption, demand release, rescan, return
    cyc(8'h0A, 0, 8'h00, 1, "R2 hold raised");
    cyc(8'h0A, 0, 8'h00, 1, "R2 no ack before holdAck");
    cyc(8'h0A, 1, 8'h02, 1, "R3 ch1 beats ch3");
    cyc(8'h0B, 1, 8'h02, 1, "R5 ch0 cannot preempt");
    cyc(8'h09, 1, 8'h00, 1, "R6 demand owner dropped");
    cyc(8'h09, 1, 8'h01, 1, "R8 rescan grants ch0");
    cyc(8'h08, 1, 8'h00, 1, "R6 ch0 released");
    cyc(8'h08, 1, 8'h08, 1, "R8 rescan grants ch3");
    cyc(8'h00, 1, 8'h00, 1, "R6 ch3 released");
    cyc(8'h00, 1, 8'h00, 0, "R9 bus returned");

    // Link channel
    cyc(8'h10, 1, 8'h00, 0, "R4 link alone no hold");
    cyc(8'h10, 1, 8'h00, 0, "R4 link alone stays idle");
    cyc(8'h30, 1, 8'h00, 1, "R4 hold from ch5");
    cyc(8'h30, 1, 8'h20, 1, "R4 ch5 granted not link");
    cyc(8'h10, 1, 8'h00, 1, "R6 ch5 released");
    cyc(8'h10, 1, 8'h00, 0, "R4 link not pending R9");

    // Single byte mode on ch2
    cyc(8'h04, 1, 8'h00, 1, "R2 hold for ch2");
    cyc(8'h04, 1, 8'h04, 1, "R7 first byte");
    cyc(8'h04, 1, 8'h00, 1, "R7 release after byte");
    cyc(8'h04, 1, 8'h04, 1, "R7 second byte");
    cyc(8'h05, 1, 8'h00, 1, "R7 release with ch0 pending");
    cyc(8'h05, 1, 8'h01, 1, "R8 ch0 wins rescan R12");
    cyc(8'h04, 1, 8'h00, 1, "R6 ch0 released");
    cyc(8'h00, 1, 8'h00, 0, "R10 ch2 gone before grant");

    // Bus master on ch6
    cyc(8'h40, 1, 8'h00, 1, "R2 hold for ch6");
    cyc(8'h40, 1, 8'h40, 1, "R11 master grant no drive");
    cyc(8'h41, 1, 8'h40, 1, "R11 master kept R5");
    cyc(8'h01, 1, 8'h00, 1, "R11 master released");
    cyc(8'h01, 1, 8'h01, 1, "R11 normal grant drives");
    cyc(8'h00, 1, 8'h00, 1, "R6 ch0 released");
    cyc(8'h00, 1, 8'h00, 0, "R9 bus returned");

    // Request withdrawn before grant
    cyc(8'h80, 0, 8'h00, 1, "R2 hold for ch7");
    cyc(8'h00, 0, 8'h00, 0, "R10 withdrawn request");
    cyc(8'h00, 1, 8'h00, 0, "R10 no late grant");
    cyc(8'h80, 0, 8'h00, 1, "R2 hold again");
    cyc(8'h00, 1, 8'h00, 0, "R10 drop as holdAck arrives");

    // Upper group ordering
    cyc(8'hE8, 1, 8'h00, 1, "R2 hold many");
    cyc(8'hE8, 1, 8'h08, 1, "R3 ch3 before upper group");
    cyc(8'hE0, 1, 8'h00, 1, "R6 ch3 released");
    cyc(8'hE0, 1, 8'h20, 1, "R3 ch5 next");
    cyc(8'hC0, 1, 8'h00, 1, "R6 ch5 released");
    cyc(8'hC0, 1, 8'h40, 1, "R3 ch6 next R11");
    cyc(8'h80, 1, 8'h00, 1, "R11 ch6 released");
    cyc(8'h80, 1, 8'h80, 1, "R3 ch7 last");
    cyc(8'h00, 1, 8'h00, 1, "R6 ch7 released");
    cyc(8'h00, 1, 8'h00, 0, "R9 bus returned");

    @(posedge clk);
    #10;
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule